// File: doc/BRIEF.md
# Program-Flow Trace Recorder

This block sits beside a processor and a shared SRAM. Each cycle the processor's trace port may flag a break in sequential execution, such as a taken branch or an exception entry, and hand over the address it left from and the address it went to. While recording is switched on, the recorder turns each such event into one two-word packet and writes it into a circular region of the SRAM. Software chooses where that region starts and how large it is. The packet is stored with a single 64-bit write on a memory port that the processor's own accesses also use. A trace write always takes the port. A processor access that collides with one is held off for one cycle.

A small register file gives software control of the recorder. Through it software can start and stop recording, read or move the write position, and see whether the buffer has wrapped. It also sets a stop mark. When the write position reaches that mark, the recorder can switch itself off, raise a one-cycle halt request to the processor, or do both.

The trace source is assumed to raise its event flag no more often than every second cycle, as branch refill on the processor guarantees.

Top module: `trace_recorder`

## Requirements
- R1: A recorded event becomes one write in the cycle after the event, with mem_we high and both strobe bits set (mem_wstrb = 2'b11) at byte address mem_addr equal to the write position. The lower 32 bits of mem_wdata hold the source address with bit 0 replaced by the exception flag, and the upper 32 bits hold the destination address.
- R2: In a cycle with a trace write, cpu_ready is low and the memory port carries the trace write. In the following cycle the held processor access reaches the port with its own address and data. For a processor write the data is placed on both lanes, and the strobe is 2'b10 when address bit 2 is 1 and 2'b01 when it is 0.
- R3: An event is recorded only if the enable bit (bit 0 of the control register at offset 0) is 1 in the cycle the event is flagged. Otherwise no write occurs and the write position stays the same.
- R4: Each recorded packet advances the write position by 8 bytes. The position register at offset 1 shows that position in bits 31:3 and the wrap flag in bit 0.
- R5: When the advanced position would equal base plus size, the position returns to base and the wrap flag sets. The wrap flag stays set until software writes the position register.
- R6: If the auto-stop bit (bit 0 of the mark register at offset 2) is 1 and a packet moves the position onto the mark address (bits 31:3 of that register), the enable bit reads 0 from the next cycle on, and later events are dropped.
- R7: If the auto-halt bit (bit 1 of the mark register) is 1 and a packet moves the position onto the mark, halt_req is high for exactly the one cycle after the write, and recording is not stopped by this alone.
- R8: The region base (offset 3, bits 31:3) and size in bytes (offset 4, bits 31:3) are written by software, read back as written, and define the wrap point.
- R9: After reset all five registers read 0, halt_req is 0, cpu_ready is 1 and, with no processor request, mem_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Non-sequential flow event this cycle |
| ev_src | input | 32 | Address the flow left from |
| ev_dst | input | 32 | Address the flow went to |
| ev_exc | input | 1 | Event is an exception entry |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| cpu_req | input | 1 | Processor memory request |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | Processor access taken this cycle |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write |
| mem_addr | output | 32 | SRAM byte address |
| mem_wdata | output | 64 | SRAM write data, lower word at the lower address |
| mem_wstrb | output | 2 | Per-word write strobes |
| halt_req | output | 1 | One-cycle halt request to the processor |

## Verification
A packet write and a processor access can land on the SRAM port in the same cycle. The bench provokes this by raising a processor request in the cycle a packet is due, using random addresses, lanes and data. In that cycle it expects the trace write on the port with cpu_ready low. In the next cycle it expects the untouched processor access with the right lane strobe. A second overlap arises when one packet both wraps the buffer and lands on the stop mark. The bench places the mark at the region base to hit this case and checks that the position, the wrap flag and the enable bit all change together.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    OFS_CTRL = 3'd0,
    OFS_POS  = 3'd1,
    OFS_MARK = 3'd2,
    OFS_BASE = 3'd3,
    OFS_SIZE = 3'd4
  } reg_ofs_e;

  localparam int unsigned PKT_SHIFT = 3;
endpackage

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ev_valid,
  input  logic [AW-1:0] ev_src,
  input  logic [AW-1:0] ev_dst,
  input  logic          ev_exc,
  output logic          pkt_v,
  output logic [AW-1:0] pkt_lo,
  output logic [AW-1:0] pkt_hi
);
  logic          take;
  logic          v_d;
  logic [AW-1:0] lo_d;

  assign take = ev_valid & en;
  assign v_d  = take;
  assign lo_d = {ev_src[AW-1:1], ev_exc};

  logic unused_src0;
  assign unused_src0 = ev_src[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_v <= 1'b0;
    end else begin
      pkt_v <= v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_lo <= '0;
      pkt_hi <= '0;
    end else if (take) begin
      pkt_lo <= lo_d;
      pkt_hi <= ev_dst;
    end
  end

  // R3: nothing is emitted for an event seen while disabled
  a_r3_off_no_packet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pkt_v);
  // R1: the packet carries the destination of the event one cycle earlier
  a_r1_dst_word: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && en |=> pkt_hi == $past(ev_dst));
endmodule

// File: rtl/trace_wptr.sv
module trace_wptr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          pos_we,
  input  logic [AW-1:0] pos_wdata,
  input  logic [AW-1:3] base,
  input  logic [AW-1:3] size,
  input  logic [AW-1:3] mark,
  input  logic          auto_stop,
  input  logic          auto_halt,
  output logic [AW-1:3] ptr,
  output logic          wrap,
  output logic          stop_req,
  output logic          halt_req
);
  logic [AW-1:3] lin_nxt;
  logic [AW-1:3] region_end;
  logic          at_end;
  logic [AW-1:3] ptr_nxt;
  logic          hit;
  logic [AW-1:3] ptr_d;
  logic          wrap_d;
  logic          halt_d;

  assign region_end = base + size;
  assign lin_nxt    = ptr + 1'b1;
  assign at_end     = (lin_nxt == region_end);
  assign ptr_nxt    = at_end ? base : lin_nxt;
  assign hit        = adv && (ptr_nxt == mark);
  assign stop_req   = hit && auto_stop;
  assign halt_d     = hit && auto_halt;

  always_comb begin
    ptr_d  = ptr;
    wrap_d = wrap;
    if (pos_we) begin
      ptr_d  = pos_wdata[AW-1:3];
      wrap_d = pos_wdata[0];
    end else if (adv) begin
      ptr_d  = ptr_nxt;
      wrap_d = wrap | at_end;
    end
  end

  logic unused_pos;
  assign unused_pos = ^pos_wdata[2:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      wrap     <= 1'b0;
      halt_req <= 1'b0;
    end else begin
      ptr      <= ptr_d;
      wrap     <= wrap_d;
      halt_req <= halt_d;
    end
  end

  // R4 / R5: a packet moves the position one slot on or back to the base
  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !pos_we |=> (ptr == $past(ptr) + 1'b1) || (ptr == $past(base)));
  // R5: wrap flag is sticky until software rewrites the position
  a_r5_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !pos_we |=> wrap);
  // R7: halt request is a single-cycle pulse
  a_r7_halt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req);
endmodule

// File: rtl/trace_regs.sv
module trace_regs
  import trace_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     cfg_rdata,
  input  logic              stop_req,
  input  logic [AW-1:3]     ptr,
  input  logic              wrap,
  output logic              en,
  output logic              pos_we,
  output logic [AW-1:3]     mark,
  output logic              auto_stop,
  output logic              auto_halt,
  output logic [AW-1:3]     base,
  output logic [AW-1:3]     size
);
  logic ctrl_we, mark_we, base_we, size_we;
  logic en_d;

  assign ctrl_we = cfg_we && (cfg_addr == OFS_CTRL);
  assign pos_we  = cfg_we && (cfg_addr == OFS_POS);
  assign mark_we = cfg_we && (cfg_addr == OFS_MARK);
  assign base_we = cfg_we && (cfg_addr == OFS_BASE);
  assign size_we = cfg_we && (cfg_addr == OFS_SIZE);

  always_comb begin
    en_d = en;
    if (stop_req) en_d = 1'b0;
    if (ctrl_we)  en_d = cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark      <= '0;
      auto_stop <= 1'b0;
      auto_halt <= 1'b0;
    end else if (mark_we) begin
      mark      <= cfg_wdata[AW-1:3];
      auto_stop <= cfg_wdata[0];
      auto_halt <= cfg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base <= '0;
    else if (base_we) base <= cfg_wdata[AW-1:3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       size <= '0;
    else if (size_we) size <= cfg_wdata[AW-1:3];
  end

  logic unused_wd;
  assign unused_wd = cfg_wdata[2];

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFS_CTRL: cfg_rdata[0] = en;
      OFS_POS:  cfg_rdata = {ptr, 2'b00, wrap};
      OFS_MARK: cfg_rdata = {mark, 1'b0, auto_halt, auto_stop};
      OFS_BASE: cfg_rdata = {base, 3'b000};
      OFS_SIZE: cfg_rdata = {size, 3'b000};
      default:  cfg_rdata = '0;
    endcase
  end

  // R6: reaching the mark with auto-stop switches recording off
  a_r6_autostop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && !ctrl_we |=> !en);
endmodule

// File: rtl/trace_arb.sv
module trace_arb #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_v,
  input  logic [AW-1:0] pkt_lo,
  input  logic [AW-1:0] pkt_hi,
  input  logic [AW-1:3] ptr,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [AW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [2*AW-1:0] mem_wdata,
  output logic [1:0]    mem_wstrb
);
  logic [1:0] cpu_strb;

  always_comb begin
    cpu_strb = 2'b00;
    if (cpu_we) cpu_strb = cpu_addr[2] ? 2'b10 : 2'b01;
  end

  always_comb begin
    if (pkt_v) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = {ptr, 3'b000};
      mem_wdata = {pkt_hi, pkt_lo};
      mem_wstrb = 2'b11;
    end else begin
      mem_en    = cpu_req;
      mem_we    = cpu_req & cpu_we;
      mem_addr  = cpu_addr;
      mem_wdata = {cpu_wdata, cpu_wdata};
      mem_wstrb = cpu_req ? cpu_strb : 2'b00;
    end
  end

  assign cpu_ready = !pkt_v;

  // R2: a processor access held off by a packet goes through next cycle
  a_r2_stall_one: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_ready |=> cpu_ready);
  // R1: a packet write is aligned to an 8-byte slot
  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> mem_we && mem_addr[2:0] == 3'b000);
endmodule

// File: rtl/trace_recorder.sv
module trace_recorder
  import trace_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [AW-1:0]     ev_src,
  input  logic [AW-1:0]     ev_dst,
  input  logic              ev_exc,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     cfg_rdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [AW-1:0]     cpu_wdata,
  output logic              cpu_ready,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [2*AW-1:0]   mem_wdata,
  output logic [1:0]        mem_wstrb,
  output logic              halt_req
);
  logic rst_m, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic          en, pos_we, auto_stop, auto_halt, wrap, stop_req;
  logic [AW-1:3] mark, base, size, ptr;
  logic          pkt_v;
  logic [AW-1:0] pkt_lo, pkt_hi;

  trace_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_s),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .stop_req(stop_req), .ptr(ptr), .wrap(wrap),
    .en(en), .pos_we(pos_we), .mark(mark),
    .auto_stop(auto_stop), .auto_halt(auto_halt),
    .base(base), .size(size)
  );

  trace_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_s), .en(en),
    .ev_valid(ev_valid), .ev_src(ev_src), .ev_dst(ev_dst), .ev_exc(ev_exc),
    .pkt_v(pkt_v), .pkt_lo(pkt_lo), .pkt_hi(pkt_hi)
  );

  trace_wptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_s),
    .adv(pkt_v), .pos_we(pos_we), .pos_wdata(cfg_wdata),
    .base(base), .size(size), .mark(mark),
    .auto_stop(auto_stop), .auto_halt(auto_halt),
    .ptr(ptr), .wrap(wrap), .stop_req(stop_req), .halt_req(halt_req)
  );

  trace_arb #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_s),
    .pkt_v(pkt_v), .pkt_lo(pkt_lo), .pkt_hi(pkt_hi), .ptr(ptr),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb)
  );
endmodule

// File: tb/sim_trace_recorder.sv
module sim_trace_recorder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [31:0] ev_src = '0, ev_dst = '0;
  logic        ev_exc = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, mem_en, mem_we, halt_req;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [1:0]  mem_wstrb;

  always #2 clk = ~clk;

  trace_recorder u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_src(ev_src),
    .ev_dst(ev_dst), .ev_exc(ev_exc), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpu_req(cpu_req),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .halt_req(halt_req)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the register state
  logic [31:0] m_ptr = '0, m_base = '0, m_size = '0, m_mark = '0;
  bit m_en = 0, m_wrap = 0, m_astop = 0, m_ahalt = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_slot(input logic [31:0] p, input logic [31:0] b,
                                            input logic [31:0] s, output bit wrapped);
    logic [31:0] n;
    n = p + 32'd8;
    wrapped = (n == b + s);
    return wrapped ? b : n;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; #0.5; d = cfg_rdata;
  endtask

  task automatic send_ev(input logic [31:0] s, input logic [31:0] d, input bit exc,
                         input bit collide, input logic [31:0] ca, input logic [31:0] cd);
    bit wrote, wrapped, hit, halt_exp;
    logic [31:0] nxt, rv;
    ev_valid = 1'b1; ev_src = s; ev_dst = d; ev_exc = exc;
    tick();
    ev_valid = 1'b0;
    if (collide) begin
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = ca; cpu_wdata = cd;
    end
    #1;
    wrote = m_en;
    if (wrote) begin
      chk(mem_en && mem_we && mem_wstrb == 2'b11, "R1 write strobes", {61'd0, mem_en, mem_wstrb}, 64'h7);
      chk(mem_addr == m_ptr, "R4 packet address", {32'd0, mem_addr}, {32'd0, m_ptr});
      chk(mem_wdata == {d, s[31:1], exc}, "R1 packet data", mem_wdata, {d, s[31:1], exc});
      if (collide) chk(cpu_ready == 1'b0, "R2 trace wins", {63'd0, cpu_ready}, 64'd0);
      nxt = next_slot(m_ptr, m_base, m_size, wrapped);
      hit = (nxt == m_mark);
      m_ptr = nxt;
      m_wrap = m_wrap | wrapped;
      if (hit && m_astop) m_en = 0;
      halt_exp = hit && m_ahalt;
    end else begin
      halt_exp = 0;
      chk(mem_en == collide && cpu_ready, "R3 no write while disabled",
          {62'd0, mem_en, cpu_ready}, {62'd0, collide, 1'b1});
    end
    tick();
    #1;
    if (collide) begin
      chk(cpu_ready && mem_en && mem_we && mem_addr == ca && mem_wdata == {cd, cd},
          "R2 held access completes", {mem_wdata[31:0], mem_addr}, {cd, ca});
      chk(mem_wstrb == (ca[2] ? 2'b10 : 2'b01), "R2 lane strobe", {62'd0, mem_wstrb},
          {62'd0, (ca[2] ? 2'b10 : 2'b01)});
    end
    cpu_req = 1'b0; cpu_we = 1'b0;
    chk(halt_req == halt_exp, "R7 halt pulse", {63'd0, halt_req}, {63'd0, halt_exp});
    rd(3'd1, rv);
    chk(rv == {m_ptr[31:3], 2'b00, m_wrap}, "R4/R5 position register", {32'd0, rv},
        {32'd0, m_ptr[31:3], 2'b00, m_wrap});
    rd(3'd0, rv);
    chk(rv == {31'd0, m_en}, "R6 enable state", {32'd0, rv}, {63'd0, m_en});
    tick();
    chk(halt_req == 1'b0, "R7 halt one cycle", {63'd0, halt_req}, 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'h5EED_0042));
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R9: reset state
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], rv);
      chk(rv == 32'd0, "R9 register reset", {32'd0, rv}, 64'd0);
    end
    chk(!halt_req && cpu_ready && !mem_en, "R9 outputs at reset",
        {61'd0, halt_req, cpu_ready, mem_en}, 64'h2);

    // R8: region setup and readback
    m_base = 32'h2000_0100; m_size = 32'h40;
    wr(3'd3, m_base); wr(3'd4, m_size);
    m_ptr = m_base; wr(3'd1, m_base);
    rd(3'd3, rv); chk(rv == m_base, "R8 base readback", {32'd0, rv}, {32'd0, m_base});
    rd(3'd4, rv); chk(rv == m_size, "R8 size readback", {32'd0, rv}, {32'd0, m_size});
    m_mark = 32'h0000_0008; wr(3'd2, m_mark);  // mark outside region, no flags
    rd(3'd2, rv); chk(rv == m_mark, "R8 mark readback", {32'd0, rv}, {32'd0, m_mark});
    m_en = 1; wr(3'd0, 32'd1);

    // R1, R2, R4, R5: random packets, random collisions, several wraps
    for (int i = 0; i < 40; i++) begin
      send_ev($urandom, $urandom, 1'($urandom), 1'($urandom), $urandom & 32'hFFFF_FFFC, $urandom);
    end
    chk(m_wrap == 1'b1, "R5 wrap seen", {63'd0, m_wrap}, 64'd1);

    // R3: disabled, events ignored
    m_en = 0; wr(3'd0, 32'd0);
    send_ev(32'hAAAA_0000, 32'hBBBB_0000, 1'b1, 1'b0, 32'd0, 32'd0);
    send_ev(32'h1234_5678, 32'h8765_4320, 1'b0, 1'b1, 32'h3000_0004, 32'hCAFE_F00D);

    // R5: software clears wrap
    m_ptr = m_base; m_wrap = 0; wr(3'd1, m_base);
    rd(3'd1, rv); chk(rv == m_base, "R5 wrap cleared by write", {32'd0, rv}, {32'd0, m_base});

    // R6: auto-stop after three packets
    m_mark = m_base + 32'h18; m_astop = 1; m_ahalt = 0; wr(3'd2, m_mark | 32'h1);
    m_en = 1; wr(3'd0, 32'd1);
    for (int i = 0; i < 4; i++) send_ev($urandom, $urandom, 1'b0, 1'b0, 32'd0, 32'd0);
    chk(m_en == 0, "R6 stopped at mark", {63'd0, m_en}, 64'd0);

    // R5 + R6: wrap and stop in the same packet (mark at base)
    m_ptr = m_base + m_size - 32'd8; m_wrap = 0; wr(3'd1, m_ptr);
    m_mark = m_base; wr(3'd2, m_mark | 32'h1);
    m_en = 1; wr(3'd0, 32'd1);
    send_ev(32'h0000_1000, 32'h0000_2000, 1'b1, 1'b1, 32'h3000_0000, 32'h0BAD_BEEF);

    // R7: auto-halt only, recording continues
    m_ptr = m_base; m_wrap = 0; wr(3'd1, m_base);
    m_mark = m_base + 32'h10; m_astop = 0; m_ahalt = 1; wr(3'd2, m_mark | 32'h2);
    m_en = 1; wr(3'd0, 32'd1);
    for (int i = 0; i < 3; i++) send_ev($urandom, $urandom, 1'b1, 1'($urandom), $urandom & 32'hFFFF_FFFC, $urandom);
    chk(m_en == 1, "R7 halt does not stop", {63'd0, m_en}, 64'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule